// File: doc/BRIEF.md
# Instruction Field Decoder with Register File

This block sits at the front of a simple load/store processor datapath. It receives one 32-bit instruction word, splits it into its fixed fields and classifies it. It holds the 32 general registers and returns the two source operands. Register 31 has no storage: it reads as zero and drops every write. Reads are combinational. The only write port is fed from the writeback stage through its own enable, index and data inputs, and it updates on the rising clock edge.

The decoder has the following outputs:
- a two-bit instruction class;
- separate load and store strobes;
- the destination index;
- the sign-extended 16-bit constant;
- a select for the second ALU operand (constant or register);
- a register-write request;
- an illegal-instruction flag.

The second read port is normally addressed by the rb field. For a store it is addressed by the rc field, so that port returns the data to be written to memory. Execution, memory access, PC sequencing and hazard handling live in other blocks.

Top module: `instr_decode_regfile`

## Requirements
- R1: The destination index output equals instruction bits 25:21, and the first operand output is the register named by bits 20:16.
- R2: The constant output is instruction bits 15:0 sign-extended to 32 bits (bit 15 copied into bits 31:16).
- R3: Reading index 31 on either port returns zero, including after a writeback to index 31 with the enable high.
- R4: When the writeback enable is high and the index is not 31, the data is stored on the rising clock edge and appears on a read of that index right after the edge. When the enable is low, no register changes.
- R5: The class code is derived from the opcode in bits 31:26, as follows:
  - opcode 10xxxx (legal) gives 00, ALU with register operand;
  - opcode 11xxxx (legal) gives 01, ALU with constant;
  - opcode 011100 or 011101 gives 10, branch;
  - opcode 011000 or 011001 gives 11, memory.
- R6: The load strobe is high only for opcode 011000, and the store strobe is high only for opcode 011001.
- R7: For a store, the second operand is the register named by bits 25:21. For every other opcode it is the register named by bits 15:11.
- R8: The operand-select output is 1 for a legal ALU-with-constant opcode, a load or a store, and 0 otherwise.
- R9: An ALU opcode (bit 31 set) whose low three bits are 111 is illegal. Every opcode with bit 31 clear other than 011000, 011001, 011100 and 011101 is also illegal. For an illegal opcode the flag is high, the class is 00, and the select, the strobes and the register-write request are all 0.
- R10: The register-write request is 1 for legal ALU, ALU-with-constant, branch (link register) and load opcodes, and 0 for stores.
- R11: Reset clears every register to zero.
- R12: The word 0x80611000 decodes as a legal class-00 instruction with destination 3, first operand from register 1 and second operand from register 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| wb_en | input | 1 | Writeback enable |
| wb_idx | input | 5 | Writeback register index |
| wb_data | input | XLEN | Writeback data |
| opnd_a | output | XLEN | Register named by the ra field |
| opnd_b | output | XLEN | Register named by rb, or by rc for a store |
| dst_idx | output | 5 | Destination register index |
| imm_ext | output | XLEN | Sign-extended constant |
| cls | output | 2 | Instruction class code |
| is_load | output | 1 | Load strobe |
| is_store | output | 1 | Store strobe |
| op_b_sel | output | 1 | 1 selects the constant as the ALU second operand |
| reg_write | output | 1 | Register-write request |
| illegal | output | 1 | Illegal-opcode flag |

## Verification
The decode outputs are purely combinational. A decode fault therefore shows on the ports in the same cycle as the offending opcode, and a sweep over all 64 opcodes exposes it. A corrupted register, or a write that landed at the wrong index, stays hidden until that index is read. The bench therefore writes a distinct value to every register and reads every index back through both ports in the cycle after the writes. Writes to index 31 and writes with the enable low are followed by an immediate read of the indices they could have disturbed.

// File: rtl/instr_decode_regfile.sv
module instr_decode_regfile #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr,
  input  logic            wb_en,
  input  logic [4:0]      wb_idx,
  input  logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b,
  output logic [4:0]      dst_idx,
  output logic [XLEN-1:0] imm_ext,
  output logic [1:0]      cls,
  output logic            is_load,
  output logic            is_store,
  output logic            op_b_sel,
  output logic            reg_write,
  output logic            illegal
);
  localparam int IDXW = 5;
  localparam int NREG = 2 ** IDXW;
  localparam logic [IDXW-1:0] ZREG = IDXW'(NREG - 1);

  logic [XLEN-1:0] rf [NREG-1];

  logic [5:0]      opc;
  logic [IDXW-1:0] f_rc, f_ra, f_rb, b_addr;
  logic            alu_ok, br, ld, st;

  assign opc  = instr[31:26];
  assign f_rc = instr[25:21];
  assign f_ra = instr[20:16];
  assign f_rb = instr[15:11];

  assign alu_ok = opc[5] && (opc[2:0] != 3'b111);
  assign br     = (opc[5:1] == 5'b01110);
  assign ld     = (opc == 6'b011000);
  assign st     = (opc == 6'b011001);

  assign illegal   = !(alu_ok || br || ld || st);
  assign is_load   = ld;
  assign is_store  = st;
  assign reg_write = alu_ok || br || ld;
  assign op_b_sel  = (alu_ok && opc[4]) || ld || st;
  assign cls       = alu_ok    ? {1'b0, opc[4]} :
                     br        ? 2'b10 :
                     (ld || st) ? 2'b11 : 2'b00;

  assign dst_idx = f_rc;
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign b_addr  = st ? f_rc : f_rb;

  assign opnd_a = (f_ra == ZREG)   ? '0 : rf[f_ra];
  assign opnd_b = (b_addr == ZREG) ? '0 : rf[b_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG - 1; i++) rf[i] <= '0;
    end else if (wb_en && wb_idx != ZREG) begin
      rf[wb_idx] <= wb_data;
    end
  end
endmodule

// File: rtl/instr_decode_regfile_chk.sv
module instr_decode_regfile_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     instr,
  input logic            wb_en,
  input logic [4:0]      wb_idx,
  input logic [XLEN-1:0] wb_data,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b,
  input logic [1:0]      cls,
  input logic            is_load,
  input logic            is_store,
  input logic            op_b_sel,
  input logic            reg_write,
  input logic            illegal
);
  AST_R31_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[20:16] == 5'd31) |-> (opnd_a == '0)); // R3

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && wb_en && wb_idx != 5'd31) && instr[20:16] == $past(wb_idx))
      |-> (opnd_a == $past(wb_data))); // R4

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_load && is_store)); // R6

  AST_MEM_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load || is_store) |-> (cls == 2'b11)); // R5

  AST_CONST_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    op_b_sel |-> (cls == 2'b01 || cls == 2'b11)); // R8

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!reg_write && !is_load && !is_store && !op_b_sel && cls == 2'b00)); // R9

  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    is_store |-> !reg_write); // R10
endmodule

bind instr_decode_regfile instr_decode_regfile_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .wb_en(wb_en), .wb_idx(wb_idx),
  .wb_data(wb_data), .opnd_a(opnd_a), .opnd_b(opnd_b), .cls(cls),
  .is_load(is_load), .is_store(is_store), .op_b_sel(op_b_sel),
  .reg_write(reg_write), .illegal(illegal)
);

// File: tb/sim_instr_decode_regfile.sv
module sim_instr_decode_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        wb_en = 1'b0;
  logic [4:0]  wb_idx = '0;
  logic [31:0] wb_data = '0;
  logic [31:0] opnd_a, opnd_b, imm_ext;
  logic [4:0]  dst_idx;
  logic [1:0]  cls;
  logic        is_load, is_store, op_b_sel, reg_write, illegal;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  instr_decode_regfile u0 (
    .clk(clk), .rst_n(rst_n), .instr(instr), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .opnd_a(opnd_a), .opnd_b(opnd_b), .dst_idx(dst_idx),
    .imm_ext(imm_ext), .cls(cls), .is_load(is_load), .is_store(is_store),
    .op_b_sel(op_b_sel), .reg_write(reg_write), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h9E37_79B9 * (i + 1) + 32'h0000_1111 * i;
  endfunction

  function automatic logic [31:0] rd_exp(input int i);
    return (i == 31) ? 32'h0 : pat(i);
  endfunction

  task automatic write_reg(input int idx, input logic [31:0] d, input logic en);
    @(negedge clk);
    wb_en = en; wb_idx = 5'(idx); wb_data = d;
    @(negedge clk);
    wb_en = 1'b0;
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      instr = {6'b100000, 5'd0, 5'(i), 5'(31 - i), 11'd0};
      #1;
      chk("R11 reset port a", opnd_a, 32'h0);
      chk("R11 reset port b", opnd_b, 32'h0);
    end
    rst_n = 1'b1;

    for (int i = 0; i < 32; i++) write_reg(i, pat(i), 1'b1);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      instr = {6'b100010, 5'(i), 5'(i), 5'(31 - i), 11'h5A5};
      #1;
      chk("R1 port a", opnd_a, rd_exp(i));
      chk("R1 dst", {27'd0, dst_idx}, i);
      chk("R7 port b rb", opnd_b, rd_exp(31 - i));
      instr = {6'b011001, 5'(i), 5'(31 - i), 5'((i + 7) % 32), 11'd0};
      #1;
      chk("R7 port b rc on store", opnd_b, rd_exp(i));
    end

    write_reg(31, 32'hFFFF_FFFF, 1'b1);
    instr = {6'b100000, 5'd0, 5'd31, 5'd31, 11'd0};
    #1;
    chk("R3 r31 a after write", opnd_a, 32'h0);
    chk("R3 r31 b after write", opnd_b, 32'h0);

    write_reg(9, 32'hDEAD_0009, 1'b0);
    instr = {6'b100000, 5'd0, 5'd9, 5'd8, 11'd0};
    #1;
    chk("R4 disabled write ignored", opnd_a, pat(9));
    write_reg(9, 32'h1234_5678, 1'b1);
    chk("R4 enabled write", opnd_a, 32'h1234_5678);
    chk("R4 neighbour intact", opnd_b, pat(8));

    write_reg(1, 32'd100, 1'b1);
    write_reg(2, 32'd23, 1'b1);
    instr = 32'h8061_1000;
    #1;
    chk("R12 class", {30'd0, cls}, 32'd0);
    chk("R12 illegal", {31'd0, illegal}, 32'd0);
    chk("R12 dst", {27'd0, dst_idx}, 32'd3);
    chk("R12 ra", opnd_a, 32'd100);
    chk("R12 rb", opnd_b, 32'd23);

    for (int k = 0; k < 8; k++) begin
      logic [15:0] c;
      c = 16'(k * 9371 + 32768 * (k % 2));
      instr = {6'b110000, 5'd3, 5'd1, c};
      #1;
      chk("R2 sign extension", imm_ext,
          (c >= 16'h8000) ? 32'(int'(c) - 65536) : {16'd0, c});
    end

    for (int op = 0; op < 64; op++) begin
      int fn;
      bit e_alu, e_br, e_ld, e_st, e_ill;
      logic [1:0] e_cls;
      fn = op % 8;
      e_alu = (op >= 32) && (fn != 7);
      e_br  = (op == 28) || (op == 29);
      e_ld  = (op == 24);
      e_st  = (op == 25);
      e_ill = !(e_alu || e_br || e_ld || e_st);
      e_cls = e_alu ? ((op >= 48) ? 2'd1 : 2'd0) : e_br ? 2'd2 : (e_ld || e_st) ? 2'd3 : 2'd0;
      instr = {6'(op), 5'd4, 5'd5, 16'hF00D};
      #1;
      chk("R5 class", {30'd0, cls}, {30'd0, e_cls});
      chk("R6 load", {31'd0, is_load}, {31'd0, e_ld});
      chk("R6 store", {31'd0, is_store}, {31'd0, e_st});
      chk("R8 select", {31'd0, op_b_sel}, {31'd0, (e_alu && op >= 48) || e_ld || e_st});
      chk("R9 illegal", {31'd0, illegal}, {31'd0, e_ill});
      chk("R10 write req", {31'd0, reg_write}, {31'd0, e_alu || e_br || e_ld});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule